// File: doc/BRIEF.md
# Bit-Serial Scan Test Port

This block gives an external host, typically a microcontroller that drives an SPI-style clock and data pair, a way to observe and steer a small design through a single serial scan chain. Every register in the block runs on the scan clock. A Johnson counter divides that clock by eight, so one chain bit moves per burst of eight clocks. The host therefore sends one byte-sized burst per bit, and three bytes per group of three bits.

The 24-bit chain has three fields. The nine output-control bits sit at the serial-input end and the eight sampled input pins sit at the serial-output end. A seven-bit sample of an internal event counter lies between them. A capture strobe ORs the input pins and the counter value into the chain and can never clear a bit, so the host resets the chain before each clean sample. An update strobe copies the output-control field into a holding register that drives nine output pins. Reset clears the chain and the divider phase. It leaves the holding register and the event counter alone, so a host can freeze the counter, reset the chain and still read a meaningful value.

Top module: `scan_tap`

## Requirements
- R1: While `rst_n` is low at a clock edge, the chain is cleared to all zeros and the divider returns to phase 0. After release, `sc_dout` reads 0 and a full readout returns 24 zero bits.
- R2: Counting the edges after reset release as 1, 2, 3, ..., the chain shifts only on edges 8, 16, 24, and so on. Between two shifts, `sc_dout` holds its value for seven edges.
- R3: On each shift, `sc_din` enters chain bit 0, every bit moves one place up, and `sc_dout` always equals chain bit 23. Sending a word MSB first over 24 bursts leaves the chain equal to that word, and the first bit read back is its bit 23.
- R4: On an edge with `sc_set` high, `do_q` takes chain bits 8..0 as they were before that edge, with `do_q[0]` taken from chain bit 0.
- R5: `do_q` changes on no edge where `sc_set` is low. Shifting and reset leave it unchanged.
- R6: On an edge with `sc_get` high and reset inactive, the capture word is ORed into the chain value that results from that edge's shift, if there is one. A bit that is already 1 stays 1.
- R7: The capture word places `di[7:0]` in chain bits 23..16, with `di[7]` in bit 23. It places the event counter's bits 6..0 in chain bits 15..9, with counter bit 6 in bit 15. Chain bits 8..0 are zero in the capture word.
- R8: The seven-bit event counter increments by one, modulo 128, on every edge where `cnt_en` is high. It holds its value otherwise and is not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan clock; every register uses its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the chain and the divider phase |
| sc_din | input | 1 | Serial data; must be held for a whole eight-clock burst |
| sc_get | input | 1 | Capture strobe: ORs the input pins and the counter into the chain |
| sc_set | input | 1 | Update strobe: copies the output-control field to `do_q` |
| cnt_en | input | 1 | Lets the internal event counter advance |
| di | input | 8 | Input pins that a capture samples |
| sc_dout | output | 1 | Last bit of the chain |
| do_q | output | 9 | Held output-control bits |

## Verification
The hardest state to reach from the ports is a capture that lands on a chain that is not clean. That is the only way to show that capturing sets bits and never clears them. The bench captures one input pattern on the first edge of a burst and a second pattern on the shift edge of the same burst, then compares the readout with the shifted first capture ORed with the second. The counter field cannot be preset through the ports. Its checks therefore compare the difference between two frozen samples with the number of enabled edges, including a window long enough to wrap the counter.

// File: rtl/scan_tap_pkg.sv
// Package: shared sizing for the scan test port.
// Assumes: the divider ratio is even and at least 4.
package scan_tap_pkg;
    localparam int DO_BITS  = 9;   // output-control field width
    localparam int CNT_BITS = 7;   // event counter field width
    localparam int DI_BITS  = 8;   // input pin field width
    localparam int DIV_RATE = 8;   // scan clocks per chain bit
endpackage

// File: rtl/scan_tap_phase.sv
// Module: Johnson-counter divider. It produces one one-hot phase vector per
// scan clock, and a shift enable in the last phase of each burst.
// Assumes: DIV is even and >= 4; synchronous active-low reset restarts phase 0.
module scan_tap_phase #(
    parameter int DIV = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [DIV-1:0] phase,
    output logic           shift_en
);
    localparam int JW = DIV / 2;

    logic [JW-1:0] ring_q;

    // Advance the twisted ring by one state per scan clock.
    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= {ring_q[JW-2:0], ~ring_q[JW-1]};
    end

    // Decode each state from one adjacent bit pair, so no two phases overlap.
    for (genvar s = 0; s < DIV; s++) begin : g_dec
        if (s == 0) begin : g_first
            assign phase[s] = ~ring_q[JW-1] & ~ring_q[0];
        end else if (s < JW) begin : g_fill
            assign phase[s] = ring_q[s-1] & ~ring_q[s];
        end else if (s == JW) begin : g_full
            assign phase[s] = ring_q[JW-1] & ring_q[0];
        end else begin : g_drain
            assign phase[s] = ~ring_q[s-JW-1] & ring_q[s-JW];
        end
    end

    assign shift_en = phase[DIV-1];
endmodule

// File: rtl/scan_tap_evcnt.sv
// Module: free-running event counter, gated by an enable.
// Assumes: no reset, so the count survives a chain reset.
module scan_tap_evcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         en,
    output logic [W-1:0] count
);
    // Count enabled edges, wrapping at 2**W.
    always_ff @(posedge clk) begin
        if (en) count <= count + 1'b1;
    end
endmodule

// File: rtl/scan_tap_chain.sv
// Module: the scan shift register. It shifts on the divider's enable and ORs
// in a parallel capture word; it can never clear a bit except on reset.
// Assumes: field order from input end: output-control, counter, input pins.
module scan_tap_chain #(
    parameter int DO_W  = 9,
    parameter int CNT_W = 7,
    parameter int DI_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        shift_en,
    input  logic                        din,
    input  logic                        get,
    input  logic [CNT_W-1:0]            cap_cnt,
    input  logic [DI_W-1:0]             cap_di,
    output logic [DO_W+CNT_W+DI_W-1:0]  chain
);
    localparam int CW = DO_W + CNT_W + DI_W;

    logic [CW-1:0] cap_word;
    logic [CW-1:0] moved;
    logic [CW-1:0] chain_nxt;

    // Place the captured fields, pins at the output end.
    assign cap_word = {cap_di, cap_cnt, {DO_W{1'b0}}};

    // Shift toward the output end, then set bits from any capture.
    always_comb begin
        moved     = shift_en ? {chain[CW-2:0], din} : chain;
        chain_nxt = get ? (moved | cap_word) : moved;
    end

    // Store the chain; reset clears every bit.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= chain_nxt;
    end
endmodule

// File: rtl/scan_tap_hold.sv
// Module: holding register for the output-control field.
// Assumes: loads only on the update strobe; untouched by the chain reset.
module scan_tap_hold #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Copy the field on the strobe, keep it otherwise.
    always_ff @(posedge clk) begin
        if (load) q <= d;
    end
endmodule

// File: rtl/scan_tap.sv
// Module: top of the bit-serial scan test port.
// Assumes: the host holds sc_din for a whole burst and keeps bursts aligned
// to reset release; strobes are sampled on scan clock edges.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int DO_W  = DO_BITS,
    parameter int CNT_W = CNT_BITS,
    parameter int DI_W  = DI_BITS,
    parameter int DIV   = DIV_RATE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sc_din,
    input  logic            sc_get,
    input  logic            sc_set,
    input  logic            cnt_en,
    input  logic [DI_W-1:0] di,
    output logic            sc_dout,
    output logic [DO_W-1:0] do_q
);
    localparam int CW = DO_W + CNT_W + DI_W;

    logic [DIV-1:0]   phase;
    logic             shift_en;
    logic [CNT_W-1:0] count;
    logic [CW-1:0]    chain;

    scan_tap_phase #(.DIV(DIV)) u_phase (
        .clk(clk), .rst_n(rst_n), .phase(phase), .shift_en(shift_en)
    );

    scan_tap_evcnt #(.W(CNT_W)) u_evcnt (
        .clk(clk), .en(cnt_en), .count(count)
    );

    scan_tap_chain #(.DO_W(DO_W), .CNT_W(CNT_W), .DI_W(DI_W)) u_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(sc_din),
        .get(sc_get), .cap_cnt(count), .cap_di(di), .chain(chain)
    );

    scan_tap_hold #(.W(DO_W)) u_hold (
        .clk(clk), .load(sc_set), .d(chain[DO_W-1:0]), .q(do_q)
    );

    // The serial output is the last chain stage.
    assign sc_dout = chain[CW-1];
endmodule

// File: rtl/scan_tap_checker.sv
// Module: assertion checker bound to scan_tap.
// Assumes: reset is asserted at least once before the checked behaviour.
module scan_tap_checker #(
    parameter int DO_W  = 9,
    parameter int CNT_W = 7,
    parameter int DI_W  = 8,
    parameter int DIV   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       sc_get,
    input logic                       sc_set,
    input logic                       cnt_en,
    input logic [DIV-1:0]             phase,
    input logic                       shift_en,
    input logic [CNT_W-1:0]           count,
    input logic [DO_W+CNT_W+DI_W-1:0] chain,
    input logic [DO_W-1:0]            do_q
);
    localparam int PW = $clog2(DIV);

    logic [PW-1:0] edge_cnt;
    logic          was_reset;

    // Track edges since reset release, independent of the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_cnt <= '0;
        else        edge_cnt <= edge_cnt + 1'b1;
        was_reset <= !rst_n;
    end

    // R1: the edge after a reset cycle shows a clear chain.
    always @(posedge clk) begin
        if (was_reset === 1'b1) begin
            p_reset_clear_r1: assert (chain == '0);
        end
    end

    p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(phase));

    p_shift_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> (edge_cnt == PW'(DIV - 1)));

    p_set_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sc_set |=> (do_q == $past(chain[DO_W-1:0])));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_set |=> $stable(do_q));

    p_get_setonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_get && !shift_en) |=> ((chain & $past(chain)) == $past(chain)));

    p_count_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en |=> (count == CNT_W'($past(count) + 1'b1)));
endmodule

bind scan_tap scan_tap_checker #(
    .DO_W(DO_W), .CNT_W(CNT_W), .DI_W(DI_W), .DIV(DIV)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sc_get(sc_get), .sc_set(sc_set),
    .cnt_en(cnt_en), .phase(phase), .shift_en(shift_en), .count(count),
    .chain(chain), .do_q(do_q)
);

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sc_din = 1'b0;
    logic       sc_get = 1'b0;
    logic       sc_set = 1'b0;
    logic       cnt_en = 1'b0;
    logic [7:0] di = 8'h00;
    logic       sc_dout;
    logic [8:0] do_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    scan_tap u_scan_tap (
        .clk(clk), .rst_n(rst_n), .sc_din(sc_din), .sc_get(sc_get),
        .sc_set(sc_set), .cnt_en(cnt_en), .di(di),
        .sc_dout(sc_dout), .do_q(do_q)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One rising edge; inputs were set at the preceding falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // One eight-clock burst; strobes optionally on the shift edge.
    task automatic burst(input logic b, input logic get_last, input logic set_last);
        sc_din = b;
        repeat (7) step();
        sc_get = get_last;
        sc_set = set_last;
        step();
        sc_get = 1'b0;
        sc_set = 1'b0;
    endtask

    task automatic load(input logic [23:0] w);
        for (int k = 23; k >= 0; k--) burst(w[k], 1'b0, 1'b0);
    endtask

    task automatic readout(output logic [23:0] r, input logic set_first);
        for (int k = 0; k < 24; k++) begin
            r[23-k] = sc_dout;
            burst(1'b0, 1'b0, set_first && (k == 0));
        end
    endtask

    // Reset, capture on the first shift edge, read back.
    task automatic capture(input logic [7:0] d, output logic [23:0] r);
        do_reset();
        di = d;
        burst(1'b0, 1'b1, 1'b0);
        readout(r, 1'b0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] w, r, r2;
        logic [6:0]  c0, c1;
        logic [8:0]  held;

        @(negedge clk);
        do_reset();
        chk("R1 dout after reset", 32'(sc_dout), 32'd0);

        // R2: shift happens on the eighth edge only.
        w = 24'hA5C3E1;
        load(w);
        chk("R3 first bit", 32'(sc_dout), 32'(w[23]));
        sc_din = 1'b0;
        repeat (7) step();
        chk("R2 no shift before eighth edge", 32'(sc_dout), 32'(w[23]));
        step();
        chk("R2 shift on eighth edge", 32'(sc_dout), 32'(w[22]));

        // R3/R4 sweep over several words.
        for (int i = 0; i < 10; i++) begin
            w = 24'((i * 32'h3B5A7D) ^ (32'hC0FFEE >> i));
            do_reset();
            load(w);
            readout(r, 1'b1);
            chk("R3 shift order", 32'(r), 32'(w));
            chk("R4 update copies field", 32'(do_q), 32'(w[8:0]));
        end

        // R5: outputs keep their value over reset and shifting.
        held = do_q;
        do_reset();
        chk("R5 hold over reset", 32'(do_q), 32'(held));
        load(~w);
        chk("R5 hold over shifting", 32'(do_q), 32'(held));
        readout(r, 1'b0);
        chk("R5 hold over readout", 32'(do_q), 32'(held));

        // R1: reset clears a loaded chain.
        load(24'hFFFFFF);
        do_reset();
        readout(r, 1'b0);
        chk("R1 chain cleared", 32'(r), 32'd0);

        // R7 sweep: pin field and zero output field, counter frozen.
        cnt_en = 1'b0;
        capture(8'h00, r);
        c0 = r[15:9];
        for (int d = 0; d < 256; d += 17) begin
            capture(8'(d), r);
            chk("R7 pin field", 32'(r[23:16]), 32'(d));
            chk("R7 output field zero", 32'(r[8:0]), 32'd0);
            chk("R8 frozen counter", 32'(r[15:9]), 32'(c0));
        end

        // R8: enabled edges advance the counter, including a wrap.
        for (int m = 50; m <= 150; m += 100) begin
            cnt_en = 1'b1;
            repeat (m) step();
            cnt_en = 1'b0;
            capture(8'h5A, r);
            c1 = r[15:9];
            chk("R8 counter delta", 32'(7'(c1 - c0)), 32'(7'(m)));
            c0 = c1;
        end

        // R6: second capture ORs into a shifted first capture.
        do_reset();
        di = 8'hF0;
        sc_get = 1'b1;
        step();
        sc_get = 1'b0;
        di = 8'h3C;
        repeat (6) step();
        sc_get = 1'b1;
        step();
        sc_get = 1'b0;
        readout(r2, 1'b0);
        r = 24'({8'hF0, c0, 9'd0} << 1) | {8'h3C, c0, 9'd0};
        chk("R6 capture only sets bits", 32'(r2), 32'(r));

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule